// File: doc/BRIEF.md
# Hybrid full-bridge gate sequencer

This block drives the four gates of a single-phase full bridge. One leg switches at the carrier rate. The other leg switches only at the grid rate. An external current loop supplies the duty word. Two grid inputs steer the block: a polarity flag and a near-zero indication with its slope. From these the block chooses one of four operating patterns, one for each half-cycle and one for each zero crossing.

In a half-cycle pattern, one slow switch stays on. The fast leg runs complementary PWM at the loop duty. At a zero crossing, both slow switches go off. The fast leg then runs open-loop with a duty that starts at zero and grows by a fixed step every carrier period. This charges or discharges the line-side capacitance gently. When the ramp has spent one period at full duty, the block enters the half-cycle pattern for the new polarity.

The carrier is a free-running counter. Pattern, duty and period are taken only when it wraps, so no period is ever cut short. Every change on the fast leg gets a dead-time gap.

Top module: `hybrid_bridge_pwm`

## Requirements
- R1: While reset is asserted or `en` is low, all four gates are off. A low `en` seen at a clock edge turns every gate off from that edge on.
- R2: After enable, the block stays idle with all gates off until a wrap finds `pol_valid` high. At that wrap it enters the positive half-cycle pattern if `pol_pos` is 1, or the negative one if `pol_pos` is 0, with no crossing ramp.
- R3: The carrier counter runs from 0 up to `period_i`−1 (a period below 2 counts as 2) and restarts at 0 when `en` rises. Pattern and duty change only at a wrap.
- R4: In the positive half-cycle pattern, `lf_lo_o` is on and `lf_hi_o` is off. The desired fast-leg state is upper-on for the first D ticks of each period and lower-on for the rest, where D = min(`duty_i`, period).
- R5: In the negative half-cycle pattern, `lf_hi_o` is on and `lf_lo_o` is off. The fast leg follows the same rule as in R4.
- R6: A wrap in the positive pattern with `zc_near`=1 and `slope_neg`=1 starts the falling crossing. A wrap in the negative pattern with `zc_near`=1 and `slope_neg`=0 starts the rising crossing. Any other combination leaves the pattern unchanged.
- R7: In both crossing patterns both slow gates are off. In the falling crossing the upper fast switch is on for the ramp duty and the lower one is its complement. In the rising crossing the lower fast switch is on for the ramp duty and the upper one is its complement.
- R8: The ramp duty is 0 in the first crossing period. It then grows by `step_i` each period (a step of 0 counts as 1), saturating at the full period. The wrap after the full-duty period enters the negative pattern (after the falling crossing) or the positive pattern (after the rising crossing), using the loop duty.
- R9: `duty_i` has no effect on the gates during a crossing pattern.
- R10: After every change of the desired fast-leg state, both fast gates stay off for max(`dead_i`, 1) clock cycles. The new gate then turns on.
- R11: The two switches of a leg are never on in the same cycle, including across pattern changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle with all gates off |
| pol_valid | input | 1 | Polarity flag is trustworthy |
| pol_pos | input | 1 | Grid voltage is positive |
| zc_near | input | 1 | Grid voltage is close to zero |
| slope_neg | input | 1 | Grid voltage is falling |
| period_i | input | CNT_W | Carrier period in clock ticks |
| duty_i | input | CNT_W | Loop duty in ticks; full scale equals the period |
| step_i | input | CNT_W | Ramp increment per carrier period |
| dead_i | input | DT_W | Dead-time length in clock cycles |
| hf_hi_o | output | 1 | Fast-leg upper gate |
| hf_lo_o | output | 1 | Fast-leg lower gate |
| lf_hi_o | output | 1 | Slow-leg upper gate |
| lf_lo_o | output | 1 | Slow-leg lower gate |

## Verification
The ramp monotonicity property assumes that `period_i` does not shrink while a crossing is under way. A smaller period would clip the ramp downward. The stimulus therefore holds the period constant for the whole run. The other properties only assume that the grid inputs are sampled at wraps, so the stimulus changes them freely at falling clock edges. The scoreboard counts upper-on and lower-on cycles in each carrier period, which makes the dead-time and duty checks depend on the period staying fixed. The stimulus also keeps `en` high except for deliberate drops placed between scoreboard windows.

// File: rtl/hybrid_bridge_pwm.sv
module hybrid_bridge_pwm #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol_valid,
  input  logic             pol_pos,
  input  logic             zc_near,
  input  logic             slope_neg,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             hf_hi_o,
  output logic             hf_lo_o,
  output logic             lf_hi_o,
  output logic             lf_lo_o
);
  typedef enum logic [2:0] {S_IDLE, S_POS, S_FALL, S_NEG, S_RISE} pat_t;

  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  pat_t             pat, pat_n;
  logic [CNT_W-1:0] cnt, per_q, duty_q, duty_n;
  logic [CNT_W-1:0] per_new, step_eff, loop_sat, ramp_sat;
  logic [CNT_W:0]   ramp_sum;
  logic             wrap, ramping, run;
  logic             cmd, prev, blank;
  logic [DT_W-1:0]  dtc;

  assign per_new  = (period_i < MIN_PER) ? MIN_PER : period_i;
  assign step_eff = (step_i == '0) ? ONE : step_i;
  assign loop_sat = (duty_i > per_new) ? per_new : duty_i;
  assign ramp_sum = {1'b0, duty_q} + {1'b0, step_eff};
  assign ramp_sat = (ramp_sum > {1'b0, per_new}) ? per_new : ramp_sum[CNT_W-1:0];
  assign wrap     = (cnt == per_q - ONE);
  assign ramping  = (pat == S_FALL) || (pat == S_RISE);
  assign run      = (pat != S_IDLE);

  always_comb begin
    pat_n  = pat;
    duty_n = loop_sat;
    case (pat)
      S_IDLE: begin
        if (pol_valid) pat_n = pol_pos ? S_POS : S_NEG;
        else           duty_n = '0;
      end
      S_POS: if (zc_near && slope_neg) begin
        pat_n  = S_FALL;
        duty_n = '0;
      end
      S_NEG: if (zc_near && !slope_neg) begin
        pat_n  = S_RISE;
        duty_n = '0;
      end
      S_FALL, S_RISE: begin
        if (duty_q >= per_new) pat_n = (pat == S_FALL) ? S_NEG : S_POS;
        else                   duty_n = ramp_sat;
      end
      default: begin
        pat_n  = S_IDLE;
        duty_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat    <= S_IDLE;
      cnt    <= '0;
      per_q  <= MIN_PER;
      duty_q <= '0;
    end else if (!en) begin
      pat    <= S_IDLE;
      cnt    <= '0;
      per_q  <= per_new;
      duty_q <= '0;
    end else if (wrap) begin
      pat    <= pat_n;
      cnt    <= '0;
      per_q  <= per_new;
      duty_q <= duty_n;
    end else begin
      cnt    <= cnt + ONE;
    end
  end

  assign cmd   = run && ((pat == S_RISE) ? (cnt >= duty_q) : (cnt < duty_q));
  assign blank = (cmd != prev) || (dtc != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      dtc  <= '0;
    end else begin
      prev <= cmd;
      if (cmd != prev)    dtc <= (dead_i > DT_W'(1)) ? dead_i - DT_W'(1) : '0;
      else if (dtc != '0) dtc <= dtc - DT_W'(1);
    end
  end

  assign hf_hi_o = run && cmd && !blank;
  assign hf_lo_o = run && !cmd && !blank;
  assign lf_hi_o = (pat == S_NEG);
  assign lf_lo_o = (pat == S_POS);

  // R1
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(hf_hi_o || hf_lo_o || lf_hi_o || lf_lo_o));
  // R2
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pat == S_IDLE && !pol_valid) |=> (pat == S_IDLE));
  // R3
  wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(pat) && $stable(duty_q)));
  // R8
  ramp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramping && $past(ramping)) |-> (duty_q >= $past(duty_q)));
  // R10
  hf_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hf_hi_o) |-> !$past(hf_lo_o));
  // R10
  hf_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hf_lo_o) |-> !$past(hf_hi_o));
  // R7
  lf_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lf_hi_o) |-> !$past(lf_lo_o));
  // R7
  lf_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lf_lo_o) |-> !$past(lf_hi_o));
endmodule

// File: tb/hybrid_bridge_pwm_tb_top.sv
module hybrid_bridge_pwm_tb_top;
  localparam int CW = 12;
  localparam int DW = 6;
  localparam int P  = 20;
  localparam int DT = 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic pol_valid = 1'b0, pol_pos = 1'b0, zc_near = 1'b0, slope_neg = 1'b0;
  logic [CW-1:0] period_i = CW'(P);
  logic [CW-1:0] duty_i   = '0;
  logic [CW-1:0] step_i   = CW'(6);
  logic [DW-1:0] dead_i   = DW'(DT);
  logic hf_hi, hf_lo, lf_hi, lf_lo;

  int total = 0, bad = 0;
  bit ended = 0;

  typedef struct {int n_hi; int n_lo; bit s_hi; bit s_lo; string tag;} win_t;
  win_t sb[$];

  int bpat = 0, bduty = 0, mleft = 0;
  bit mprev = 0;

  always #2 clk = ~clk;

  hybrid_bridge_pwm #(.CNT_W(CW), .DT_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .pol_valid(pol_valid), .pol_pos(pol_pos), .zc_near(zc_near), .slope_neg(slope_neg),
    .period_i(period_i), .duty_i(duty_i), .step_i(step_i), .dead_i(dead_i),
    .hf_hi_o(hf_hi), .hf_lo_o(hf_lo), .lf_hi_o(lf_hi), .lf_lo_o(lf_lo)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int d);
    return (d > P) ? P : d;
  endfunction

  // expected gate counts for one carrier period of the current model pattern
  task automatic push_win(string tag);
    win_t w;
    bit run, inv;
    run = (bpat != 0);
    inv = (bpat == 4);
    w.n_hi = 0;
    w.n_lo = 0;
    for (int c = 0; c < P; c++) begin
      bit below, cmd, blk;
      below = (c < bduty);
      cmd = run && (inv ? !below : below);
      if (cmd != mprev) begin
        blk = 1;
        mleft = (DT > 1) ? DT - 1 : 0;
      end else if (mleft > 0) begin
        blk = 1;
        mleft--;
      end else begin
        blk = 0;
      end
      mprev = cmd;
      if (run && !blk) begin
        if (cmd) w.n_hi++;
        else     w.n_lo++;
      end
    end
    w.s_hi = (bpat == 3);
    w.s_lo = (bpat == 1);
    w.tag  = tag;
    sb.push_back(w);
  endtask

  // drive inputs for the next wrap, predict the period after it, wait one period
  task automatic run_win(int d, bit zc, bit sn, bit pv, bit pp, string tag);
    int s;
    duty_i    = d[CW-1:0];
    zc_near   = zc;
    slope_neg = sn;
    pol_valid = pv;
    pol_pos   = pp;
    s = (step_i == '0) ? 1 : int'(step_i);
    case (bpat)
      0: if (pv) begin bpat = pp ? 1 : 3; bduty = sat(d); end
         else bduty = 0;
      1: if (zc && sn) begin bpat = 2; bduty = 0; end
         else bduty = sat(d);
      3: if (zc && !sn) begin bpat = 4; bduty = 0; end
         else bduty = sat(d);
      default: if (bduty >= P) begin bpat = (bpat == 2) ? 3 : 1; bduty = sat(d); end
               else bduty = sat(bduty + s);
    endcase
    push_win(tag);
    repeat (P) @(negedge clk);
  endtask

  task automatic start_seq();
    @(negedge clk);
    en = 1'b1;
    bpat = 0;
    bduty = 0;
    mprev = 0;
    mleft = 0;
    push_win("R2");
  endtask

  // monitor: pops one expected period and compares per-period gate counts
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() != 0) begin
        win_t w;
        int n_hi, n_lo, lf_bad, ov;
        w = sb.pop_front();
        n_hi = 0; n_lo = 0; lf_bad = 0; ov = 0;
        for (int i = 0; i < P; i++) begin
          if (i > 0) begin
            @(negedge clk);
            #1;
          end
          if (hf_hi) n_hi++;
          if (hf_lo) n_lo++;
          if (lf_hi !== w.s_hi || lf_lo !== w.s_lo) lf_bad++;
          if ((hf_hi && hf_lo) || (lf_hi && lf_lo)) ov++;
        end
        chk({w.tag, " fast upper on-cycles"}, n_hi, w.n_hi);
        chk({w.tag, " fast lower on-cycles"}, n_lo, w.n_lo);
        chk({w.tag, " slow leg level"}, lf_bad, 0);
        chk("R11 leg overlap", ov, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 gates in reset", int'({hf_hi, hf_lo, lf_hi, lf_lo}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 gates while disabled", int'({hf_hi, hf_lo, lf_hi, lf_lo}), 0);

    // first run: positive entry, falling crossing with step 6, rising crossing with step 7
    start_seq();
    run_win(8,  0, 0, 0, 1, "R2");
    run_win(8,  0, 0, 1, 1, "R2");
    run_win(0,  0, 0, 1, 1, "R4");
    run_win(20, 0, 0, 1, 1, "R4");
    run_win(25, 0, 0, 1, 1, "R4");
    run_win(13, 0, 0, 1, 1, "R10");
    run_win(13, 1, 0, 1, 1, "R6");
    run_win(5,  1, 1, 1, 1, "R6");
    run_win(17, 0, 0, 1, 1, "R9");
    run_win(3,  0, 0, 1, 1, "R9");
    run_win(19, 0, 0, 1, 1, "R8");
    run_win(2,  0, 0, 1, 1, "R8");
    run_win(7,  0, 0, 1, 1, "R8");
    run_win(15, 0, 0, 1, 0, "R5");
    run_win(4,  1, 1, 1, 0, "R6");
    step_i = CW'(7);
    run_win(9,  1, 0, 1, 0, "R6");
    run_win(1,  0, 0, 1, 0, "R7");
    run_win(18, 0, 0, 1, 0, "R7");
    run_win(9,  0, 0, 1, 0, "R7");
    run_win(11, 0, 0, 1, 1, "R8");
    run_win(6,  0, 0, 1, 1, "R3");
    repeat (P) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 gates after enable drop", int'({hf_hi, hf_lo, lf_hi, lf_lo}), 0);
    repeat (8) @(negedge clk);

    // second run: direct negative entry, rising crossing with a zero step
    step_i = '0;
    start_seq();
    run_win(12, 0, 0, 1, 0, "R2");
    run_win(12, 1, 0, 1, 0, "R6");
    for (int k = 0; k < 21; k++) run_win(12, 0, 0, 1, 0, "R8");
    run_win(3, 0, 0, 1, 1, "R4");
    repeat (P + 2) @(negedge clk);
    #1;
    chk("R8 scoreboard drained", sb.size(), 0);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule